// File: doc/BRIEF.md
# Universal Counter/Shift Register Slice

A 4-bit register slice with two roles, chained to build wider counters or shift registers. A 3-bit function select picks one of eight synchronous operations on each rising clock edge. It can count up or down modulo 16, shift left or right by one bit, load a parallel preset, invert every bit, clear, or hold.

Two active-low count enables gate counting. The "trickle" enable has a second job: in shift-up it is the serial bit entering bit 0. The terminal-count output also has two jobs. In the count modes it flags the terminal value. In the shift modes it carries the top bit out. One wire from a slice's terminal-count output to the next slice's trickle enable therefore links the slices for both ripple counting and shift-up. A separate serial input feeds the top bit during shift-down.

A high master reset clears the register at once and overrides everything else. Its release is synchronized to the clock. The block drives the register value and its bitwise complement.

Top module: `usr_slice`

## Requirements
- R1: While `mrst` is high, `q` reads 0 within the same cycle, regardless of the other inputs. After `mrst` falls, the first two rising edges leave `q` at 0. The third rising edge is the first to act.
- R2: With `sel`=000 (load), a rising edge copies `preset` into `q`.
- R3: With `sel`=001 (count up), a rising edge adds 1 modulo 16 when `cep_n` and `cet_n` are both 0. If either enable is 1, `q` does not change.
- R4: With `sel`=010 (count down), a rising edge subtracts 1 modulo 16 when `cep_n` and `cet_n` are both 0. If either enable is 1, `q` does not change.
- R5: With `sel`=011 (complement), a rising edge inverts every bit of `q`.
- R6: With `sel`=100 (clear), a rising edge sets `q` to 0.
- R7: With `sel`=101 (shift up), a rising edge moves bit i to bit i+1 and loads `cet_n` into bit 0. `cep_n` has no effect.
- R8: With `sel`=110 (shift down), a rising edge moves bit i+1 to bit i and loads `sdn` into bit 3.
- R9: With `sel`=111 (hold), `q` does not change. In every mode other than load, `preset` has no effect.
- R10: In count up, `tc_n` is 0 exactly when `q`=15 and `cet_n`=0. In count down, `tc_n` is 0 exactly when `q`=0 and `cet_n`=0. `cep_n` does not affect `tc_n`.
- R11: In the two shift modes `tc_n` equals `q[3]`. In load, complement, clear and hold, `tc_n` is 1.
- R12: `q_n` is always the bitwise inverse of `q`.
- R13: Two slices with the lower slice's `tc_n` wired to the upper slice's `cet_n` behave as one 8-bit register. They count up and down modulo 256, and the upper slice's `tc_n` flags 255 (up) or 0 (down). They also shift up as an 8-bit chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| mrst | input | 1 | Master reset, active high, asynchronous clear |
| sel | input | 3 | Function select |
| cep_n | input | 1 | Parallel count enable, active low |
| cet_n | input | 1 | Trickle count enable (active low); serial input for shift up |
| sdn | input | 1 | Serial input for shift down, enters bit 3 |
| preset | input | 4 | Parallel load data |
| q | output | 4 | Register value |
| q_n | output | 4 | Bitwise complement of `q` |
| tc_n | output | 1 | Terminal count (active low) in count modes; top bit in shift modes |

## Verification
The sweep loads each of the 16 values and then applies each of the eight functions under all eight combinations of `cep_n`, `cet_n` and `sdn`. The preset is inverted during the second cycle.

- Count results separate correct wraparound and enable gating from off-by-one or ungated updates.
- Shift results show which bit enters at each end.
- Terminal-count samples show that only `cet_n` gates the flag and that shift modes echo the top bit.

A two-slice chain counts through 256 states in both directions and shifts a bit pattern up. This shows that one wire carries both the carry and the serial bit. Reset pulses in the middle of operation confirm the immediate clear and the two-edge delay on release.

// File: rtl/usr_pkg.sv
`timescale 1ns/1ps
package usr_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'b000,
    OP_INC  = 3'b001,
    OP_DEC  = 3'b010,
    OP_INV  = 3'b011,
    OP_CLR  = 3'b100,
    OP_SUP  = 3'b101,
    OP_SDN  = 3'b110,
    OP_KEEP = 3'b111
  } usr_op_e;
endpackage

// File: rtl/usr_rst_sync.sv
`timescale 1ns/1ps
// Asserts immediately on arst, releases after STAGES rising edges.
module usr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain_q <= '0;
    else      chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/usr_next.sv
`timescale 1ns/1ps
// Next-state and clock-enable generation for the slice register.
module usr_next
  import usr_pkg::*;
#(
  parameter int W = 4
) (
  input  usr_op_e        op,
  input  logic [W-1:0]   cur,
  input  logic           cep_n,
  input  logic           cet_n,
  input  logic           sdn,
  input  logic [W-1:0]   preset,
  output logic [W-1:0]   nxt,
  output logic           en
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] up_lane;
  logic [W-1:0] dn_lane;
  logic         cnt_ok;

  // Per-bit shift lanes: each bit picks its neighbour or the serial input.
  for (genvar i = 0; i < W; i++) begin : g_lane
    if (i == 0) begin : g_lo
      assign up_lane[i] = cet_n;
    end else begin : g_up
      assign up_lane[i] = cur[i-1];
    end
    if (i == W-1) begin : g_hi
      assign dn_lane[i] = sdn;
    end else begin : g_dn
      assign dn_lane[i] = cur[i+1];
    end
  end

  assign cnt_ok = ~cep_n & ~cet_n;

  always_comb begin
    nxt = cur;
    en  = 1'b1;
    unique case (op)
      OP_LOAD: nxt = preset;
      OP_INC:  begin nxt = cur + ONE; en = cnt_ok; end
      OP_DEC:  begin nxt = cur - ONE; en = cnt_ok; end
      OP_INV:  nxt = ~cur;
      OP_CLR:  nxt = '0;
      OP_SUP:  nxt = up_lane;
      OP_SDN:  nxt = dn_lane;
      OP_KEEP: en  = 1'b0;
      default: en  = 1'b0;
    endcase
  end
endmodule

// File: rtl/usr_term.sv
`timescale 1ns/1ps
// Terminal-count / serial-out decode.
module usr_term
  import usr_pkg::*;
#(
  parameter int W = 4
) (
  input  usr_op_e      op,
  input  logic [W-1:0] cur,
  input  logic         cet_n,
  output logic         tc_n
);
  logic at_top;
  logic at_bot;

  assign at_top = &cur;
  assign at_bot = ~|cur;

  always_comb begin
    unique case (op)
      OP_INC:          tc_n = ~(at_top & ~cet_n);
      OP_DEC:          tc_n = ~(at_bot & ~cet_n);
      OP_SUP, OP_SDN:  tc_n = cur[W-1];
      default:         tc_n = 1'b1;
    endcase
  end
endmodule

// File: rtl/usr_slice.sv
`timescale 1ns/1ps
module usr_slice
  import usr_pkg::*;
#(
  parameter int W          = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         mrst,
  input  logic [2:0]   sel,
  input  logic         cep_n,
  input  logic         cet_n,
  input  logic         sdn,
  input  logic [W-1:0] preset,
  output logic [W-1:0] q,
  output logic [W-1:0] q_n,
  output logic         tc_n
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  usr_op_e      op;
  logic         rst_n;
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         q_en;

  assign op = usr_op_e'(sel);

  usr_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk    (clk),
    .arst   (mrst),
    .rst_no (rst_n)
  );

  usr_next #(.W(W)) u_next (
    .op     (op),
    .cur    (q_r),
    .cep_n  (cep_n),
    .cet_n  (cet_n),
    .sdn    (sdn),
    .preset (preset),
    .nxt    (q_d),
    .en     (q_en)
  );

  usr_term #(.W(W)) u_term (
    .op    (op),
    .cur   (q_r),
    .cet_n (cet_n),
    .tc_n  (tc_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_d;
  end

  assign q   = q_r;
  assign q_n = ~q_r;

  // R1: register still cleared on the first edge after reset release
  p_release_clear_r1: assert property (@(posedge clk) $rose(rst_n) |-> q_r == '0);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> q_r == $past(preset));
  p_inc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC && !cep_n && !cet_n) |=> q_r == $past(q_r) + ONE);
  p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DEC && !cep_n && !cet_n) |=> q_r == $past(q_r) - ONE);
  p_cnt_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_INC || op == OP_DEC) && (cep_n || cet_n)) |=> $stable(q_r));
  p_invert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_INV |=> q_r == ~$past(q_r));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CLR |=> q_r == '0);
  p_shift_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SUP |=> q_r == {$past(q_r[W-2:0]), $past(cet_n)});
  p_shift_dn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SDN |=> q_r == {$past(sdn), $past(q_r[W-1:1])});
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_KEEP |=> $stable(q_r));
  p_tc_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD || op == OP_INV || op == OP_CLR || op == OP_KEEP) |-> tc_n);
endmodule

// File: tb/tb_usr_slice.sv
`timescale 1ns/1ps
module tb_usr_slice;
  logic       clk = 1'b0;
  logic       mrst;
  logic [2:0] sel;
  logic       cep_n, cet_n, sdn, sdn_hi;
  logic [3:0] preset, preset_hi;
  logic [3:0] q, q_n, q_hi, q_n_hi;
  logic       tc_n, tc_n_hi;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [3:0] m_q;
  logic [7:0] m8;

  always #5 clk = ~clk;

  usr_slice dut (
    .clk(clk), .mrst(mrst), .sel(sel), .cep_n(cep_n), .cet_n(cet_n),
    .sdn(sdn), .preset(preset), .q(q), .q_n(q_n), .tc_n(tc_n)
  );

  usr_slice u_hi (
    .clk(clk), .mrst(mrst), .sel(sel), .cep_n(cep_n), .cet_n(tc_n),
    .sdn(sdn_hi), .preset(preset_hi), .q(q_hi), .q_n(q_n_hi), .tc_n(tc_n_hi)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic [2:0] op, input logic [3:0] c,
      input logic cp, input logic ct, input logic sd, input logic [3:0] pr);
    case (op)
      3'd0: return pr;
      3'd1: return (!cp && !ct) ? 4'((c + 1) % 16) : c;
      3'd2: return (!cp && !ct) ? 4'((c + 15) % 16) : c;
      3'd3: return 4'(15 - c);
      3'd4: return 4'd0;
      3'd5: return {c[2:0], ct};
      3'd6: return {sd, c[3:1]};
      default: return c;
    endcase
  endfunction

  function automatic logic tc_model(input logic [2:0] op, input logic [3:0] c, input logic ct);
    case (op)
      3'd1: return !(c == 15 && ct == 1'b0);
      3'd2: return !(c == 0 && ct == 1'b0);
      3'd5, 3'd6: return c[3];
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // One cycle on the lower slice: check q/q_n, drive, check tc_n, clock the model.
  task automatic step(input logic [2:0] op, input logic cp, input logic ct,
                      input logic sd, input logic [3:0] pr);
    @(negedge clk);
    chk(tag(sel), {4'h0, q}, {4'h0, m_q});
    chk("R12", {4'h0, q_n}, {4'h0, ~m_q});
    sel = op; cep_n = cp; cet_n = ct; sdn = sd; preset = pr;
    #1;
    chk((op == 3'd5 || op == 3'd6 || op == 3'd0 || op == 3'd3 || op == 3'd4 || op == 3'd7)
        ? "R11" : "R10", {7'h0, tc_n}, {7'h0, tc_model(op, m_q, ct)});
    @(posedge clk);
    m_q = model(op, m_q, cp, ct, sd, pr);
  endtask

  // One cycle on the two-slice chain.
  task automatic casc(input logic [2:0] op, input logic ct);
    @(negedge clk);
    chk("R13", {q_hi, q}, m8);
    sel = op; cep_n = 1'b0; cet_n = ct; sdn = 1'b0; sdn_hi = 1'b0;
    #1;
    if (op == 3'd1) chk("R13", {7'h0, tc_n_hi}, {7'h0, !(m8 == 8'hFF && !ct)});
    if (op == 3'd2) chk("R13", {7'h0, tc_n_hi}, {7'h0, !(m8 == 8'h00 && !ct)});
    @(posedge clk);
    case (op)
      3'd1: if (!ct) m8 = m8 + 8'd1;
      3'd2: if (!ct) m8 = m8 - 8'd1;
      3'd5: m8 = {m8[6:0], ct};
      default: ;
    endcase
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    mrst = 1'b1; sel = 3'd7; cep_n = 1'b1; cet_n = 1'b1; sdn = 1'b0; sdn_hi = 1'b0;
    preset = 4'h0; preset_hi = 4'h0; m_q = 4'h0; m8 = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {4'h0, q}, 8'h00);
    chk("R12", {4'h0, q_n}, 8'h0F);

    // R1: release, two edges with load requested do nothing, third loads
    sel = 3'd0; preset = 4'hA; mrst = 1'b0;
    @(posedge clk); @(negedge clk); chk("R1", {4'h0, q}, 8'h00);
    @(posedge clk); @(negedge clk); chk("R1", {4'h0, q}, 8'h00);
    @(posedge clk); @(negedge clk); chk("R1", {4'h0, q}, 8'h0A);
    m_q = 4'hA;

    // Exhaustive sweep: every start value, function and control pattern
    for (int v = 0; v < 16; v++)
      for (int op = 0; op < 8; op++)
        for (int c = 0; c < 8; c++) begin
          step(3'd0, 1'b1, 1'b1, 1'b0, 4'(v));
          step(3'(op), c[0], c[1], c[2], 4'(15 - v));
        end
    step(3'd7, 1'b1, 1'b1, 1'b0, 4'h0);

    // R1: reset in mid-cycle clears at once and overrides a load
    step(3'd0, 1'b1, 1'b1, 1'b0, 4'h9);
    @(negedge clk);
    chk("R2", {4'h0, q}, 8'h09);
    #2 mrst = 1'b1;
    #1 chk("R1", {4'h0, q}, 8'h00);
    sel = 3'd0; preset = 4'h5;
    @(posedge clk); @(negedge clk); chk("R1", {4'h0, q}, 8'h00);
    mrst = 1'b0; sel = 3'd7;
    repeat (3) @(posedge clk);
    m_q = 4'h0;

    // R13: two-slice cascade
    @(negedge clk);
    sel = 3'd0; preset = 4'hD; preset_hi = 4'hF;
    @(posedge clk);
    m8 = 8'hFD;
    for (int i = 0; i < 300; i++) casc(3'd1, 1'b0);
    for (int i = 0; i < 6; i++) casc(3'd1, 1'b1);
    for (int i = 0; i < 300; i++) casc(3'd2, 1'b0);
    for (int i = 0; i < 20; i++) casc(3'd5, 1'((i * 7 + 3) % 5 < 2));
    casc(3'd7, 1'b1);
    @(negedge clk);
    chk("R13", {q_hi, q}, m8);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule